// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a synchronous host port and one 2M x 8 asynchronous EDO DRAM. Each host request moves a single byte. The block splits the 21-bit word address into a 12-bit row and a 9-bit column and drives them one after the other on a shared 12-bit pin bus. Only the row phase uses the top three pins. The block drives the row strobe, column strobe, write strobe and output-enable strobe. It counts every timing interval in system clock cycles, and it derives those counts at elaboration from nanosecond parameters and the clock period.

After an access, the row stays open. A later request to the same row starts a new column cycle straight away, without a new row phase. The row closes in four cases:
- a request arrives for a different row,
- a refresh is requested,
- the row-open window runs out while the port is idle,
- a new access could no longer finish inside that window.

Writes are early writes, so the DRAM's own output stays off for the whole cycle. Refresh requests use a column-before-row refresh. The block grants them only from idle, when the row strobe is high.

Top module: `edo_seq`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high while `ref_req` is low.
- R2: During the row phase, `dram_addr` equals `req_addr[20:9]`. During the column setup, column-low, column-precharge and page-open states, `dram_addr` equals `{3'b000, req_addr[8:0]}`.
- R3: A request accepted from idle produces the following sequence:
  - `dram_ras_n` goes low with the row address for RCDH cycles;
  - one column setup cycle follows, with `dram_cas_n` high;
  - `dram_cas_n` is then low for CASH cycles.
  - Here T is the clock period in ns, CASH = max(ceil(tCAS/T), ceil(tCAC/T)) and RCDH = max(ceil(tRCD/T), ceil(tRAC/T) - CASH).
- R4: In a read, `dram_oe_n` is low during the setup and column-low cycles. `rsp_valid` is high for exactly one cycle, the cycle right after the last column-low cycle, and `rsp_rdata` then holds the `dram_dq_in` value from that last column-low cycle.
- R5: In a write, `dram_we_n` is low and `dram_dq_oe` is high with `dram_dq_out` equal to the write data. Both start in the setup cycle, one cycle before `dram_cas_n` falls, and last through the column-low cycles. `dram_oe_n` stays high for the whole write.
- R6: After the column-low cycles, `dram_cas_n` is high for CPH = max(ceil(tCP/T), ceil(tHPC/T) - CASH) cycles. The block then enters a page-open state with `dram_ras_n` still low. A same-row request is accepted there and goes straight to the column setup cycle.
- R7: In the page-open state, a request for a different row sees `req_ready` low. The row strobe then rises for RPH = ceil(tRP/T) cycles, and the request is accepted from idle.
- R8: Between a rise and the next fall of `dram_ras_n`, the row strobe is high for at least RPH cycles.
- R9: A single low run of `dram_ras_n` never lasts longer than floor(tRASPmax/T) cycles. If the port stays idle, the page-open state closes the row by itself before that limit.
- R10: In idle, a high `ref_req` takes priority over `req_valid`. `ref_ack` is high and `req_ready` is low in that cycle. Then the following happens in order:
  - `dram_cas_n` falls one cycle before `dram_ras_n`;
  - both strobes stay low for RASH = ceil(tRAS/T) cycles with `dram_we_n` high;
  - RPH cycles of precharge follow.
- R11: In the page-open state, a high `ref_req` makes `req_ready` low and closes the row. `ref_ack` stays low until the block is back in idle with `dram_ras_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address: bits 20:9 row, bits 8:0 column |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| ref_req | input | 1 | Refresh wanted (level) |
| ref_ack | output | 1 | Refresh granted this cycle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed address pins; bits 11:9 are row-only |
| dram_dq_out | output | 8 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the DRAM |

## Verification
Take the acceptance edge as cycle 0.
- **Access from idle:** the row phase fills cycles 1 to RCDH, the setup cycle is RCDH+1, and the column strobe is low from RCDH+2 to RCDH+1+CASH. The read strobe is due in cycle RCDH+2+CASH.
- **Access from an open page:** the setup cycle is cycle 1 and the read strobe is due in cycle 2+CASH.
- **Refresh:** after the grant edge, the column strobe falls in cycle 1 and the row strobe falls in cycle 2.

The bench walks each of these phases one cycle at a time, sampling on the falling clock edge, and compares every strobe and address value. A behavioural DRAM model and monitor run on every clock and check precharge gaps, the row-open window and the stored data.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int DATA_W = 8;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W  = ROW_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_ASU,
        ST_COL,
        ST_CP,
        ST_PAGE,
        ST_PRE,
        ST_REFC,
        ST_REFR
    } edo_state_e;

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } edo_req_t;

    // Round a nanosecond interval up to whole clock cycles, at least one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // States in which the row strobe is held low.
    function automatic logic ras_low(input edo_state_e s);
        return (s == ST_ROW) || (s == ST_ASU) || (s == ST_COL) ||
               (s == ST_CP)  || (s == ST_PAGE) || (s == ST_REFR);
    endfunction

endpackage

// File: rtl/edo_hold_ctr.sv
module edo_hold_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_win_ctr.sv
module edo_win_ctr #(
    parameter int CNT_W   = 8,
    parameter int LIMIT   = 95,
    parameter int MAX_RUN = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             low_next,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (!low_next)
            count <= '0;
        else if (count != {CNT_W{1'b1}})
            count <= count + 1'b1;
    end

    assign expired = (count >= CNT_W'(LIMIT));

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(MAX_RUN)); // R9
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux
    import edo_seq_pkg::*;
(
    input  edo_state_e       st,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [PIN_W-1:0] pins
);
    always_comb begin
        case (st)
            ST_ROW:                        pins = row;
            ST_ASU, ST_COL, ST_CP, ST_PAGE: pins = {{(PIN_W-COL_W){1'b0}}, col};
            default:                       pins = '0;
        endcase
    end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int CLK_NS        = 8,
    parameter int T_RCD_NS      = 14,
    parameter int T_RAC_NS      = 50,
    parameter int T_CAS_NS      = 8,
    parameter int T_CAC_NS      = 13,
    parameter int T_CP_NS       = 8,
    parameter int T_HPC_NS      = 20,
    parameter int T_RP_NS       = 30,
    parameter int T_RAS_NS      = 50,
    parameter int T_RASP_MAX_NS = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [20:0]       req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [11:0]       dram_addr,
    output logic [7:0]        dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [7:0]        dram_dq_in
);
    localparam int CAS_HOLD = imax(ns2cyc(T_CAS_NS, CLK_NS), ns2cyc(T_CAC_NS, CLK_NS));
    localparam int RCD_HOLD = imax(ns2cyc(T_RCD_NS, CLK_NS), ns2cyc(T_RAC_NS, CLK_NS) - CAS_HOLD);
    localparam int CP_HOLD  = imax(ns2cyc(T_CP_NS, CLK_NS), ns2cyc(T_HPC_NS, CLK_NS) - CAS_HOLD);
    localparam int RP_HOLD  = ns2cyc(T_RP_NS, CLK_NS);
    localparam int RAS_HOLD = ns2cyc(T_RAS_NS, CLK_NS);
    localparam int RASP_CYC = T_RASP_MAX_NS / CLK_NS;
    localparam int WIN_LIM  = RASP_CYC - (1 + CAS_HOLD + CP_HOLD) - 1;
    localparam int HOLD_MAX = imax(imax(RCD_HOLD, CAS_HOLD), imax(imax(CP_HOLD, RP_HOLD), RAS_HOLD));
    localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
    localparam int WIN_W    = $clog2(RASP_CYC + 2);

    edo_state_e       state, nxt;
    edo_req_t         cur;
    logic             hold_done;
    logic [WIN_W-1:0] win_cnt;
    logic             win_expired;
    logic             row_match;
    logic             accept;
    logic             col_phase;

    function automatic int hold_of(input edo_state_e s);
        case (s)
            ST_ROW:  return RCD_HOLD;
            ST_COL:  return CAS_HOLD;
            ST_CP:   return CP_HOLD;
            ST_PRE:  return RP_HOLD;
            ST_REFR: return RAS_HOLD;
            default: return 1;
        endcase
    endfunction

    edo_hold_ctr #(.CNT_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (nxt != state),
        .load_val (HOLD_W'(hold_of(nxt) - 1)),
        .done     (hold_done)
    );

    edo_win_ctr #(.CNT_W(WIN_W), .LIMIT(WIN_LIM), .MAX_RUN(RASP_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .low_next (ras_low(nxt)),
        .count    (win_cnt),
        .expired  (win_expired)
    );

    edo_addr_mux u_amux (
        .st   (state),
        .row  (cur.row),
        .col  (cur.col),
        .pins (dram_addr)
    );

    assign row_match = (req_addr[ADDR_W-1:COL_W] == cur.row);
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt       = state;
        req_ready = 1'b0;
        ref_ack   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ref_req) begin
                    ref_ack = 1'b1;
                    nxt     = ST_REFC;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) nxt = ST_ROW;
                end
            end
            ST_ROW:  if (hold_done) nxt = ST_ASU;
            ST_ASU:  nxt = ST_COL;
            ST_COL:  if (hold_done) nxt = ST_CP;
            ST_CP:   if (hold_done) nxt = ST_PAGE;
            ST_PAGE: begin
                req_ready = !ref_req && row_match && !win_expired;
                if (ref_req)
                    nxt = ST_PRE;
                else if (req_valid && req_ready)
                    nxt = ST_ASU;
                else if (req_valid || win_expired)
                    nxt = ST_PRE;
            end
            ST_PRE:  if (hold_done) nxt = ST_IDLE;
            ST_REFC: nxt = ST_REFR;
            ST_REFR: if (hold_done) nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= nxt;
            rsp_valid <= 1'b0;
            if (accept) begin
                cur.wr    <= req_write;
                cur.row   <= req_addr[ADDR_W-1:COL_W];
                cur.col   <= req_addr[COL_W-1:0];
                cur.wdata <= req_wdata;
            end
            if (state == ST_COL && hold_done && !cur.wr) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= dram_dq_in;
            end
        end
    end

    assign col_phase   = (state == ST_ASU) || (state == ST_COL);
    assign dram_ras_n  = !ras_low(state);
    assign dram_cas_n  = !((state == ST_COL) || (state == ST_REFC) || (state == ST_REFR));
    assign dram_we_n   = !(cur.wr && col_phase);
    assign dram_oe_n   = !(!cur.wr && col_phase);
    assign dram_dq_oe  = cur.wr && col_phase;
    assign dram_dq_out = cur.wdata;

    // Checker state: cycles the row strobe has been high so far.
    logic [15:0] a_hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            a_hi_run <= 16'(RP_HOLD);
        else if (!dram_ras_n)
            a_hi_run <= '0;
        else if (a_hi_run != 16'hFFFF)
            a_hi_run <= a_hi_run + 1'b1;
    end

    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (a_hi_run >= 16'(RP_HOLD))); // R8
    AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0)); // R5
    AST_DQ_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> dram_oe_n); // R5
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && !dram_cas_n) |-> (dram_we_n && ($past(dram_cas_n) == 1'b0))); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4
    AST_REF_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> (dram_ras_n && dram_cas_n && !req_ready)); // R11
endmodule

// File: tb/edo_seq_bench.sv
module edo_seq_bench;
    localparam int CLK_NS = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CASH = mx(cyc(8), cyc(13));
    localparam int RCDH = mx(cyc(14), cyc(50) - CASH);
    localparam int CPH  = mx(cyc(8), cyc(20) - CASH);
    localparam int RPH  = cyc(30);
    localparam int RASH = cyc(50);
    localparam int RASP = 800 / CLK_NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  dram_dq_in = '0;
    logic req_ready, rsp_valid, ref_ack;
    logic [7:0] rsp_rdata, dram_dq_out;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    edo_seq #(.T_RASP_MAX_NS(800)) u_edo_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    function automatic logic [7:0] dflt(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural DRAM and protocol monitor, evaluated every clock.
    logic [7:0] dmem [int];
    logic [7:0] shadow [int];
    logic [11:0] m_row;
    logic [8:0]  m_col;
    logic        m_prev;
    int          hi_run, lo_run;

    always @(negedge clk) begin
        if (rst) begin
            m_prev = 1'b1; hi_run = 100; lo_run = 0;
        end else begin
            if (m_prev && !dram_ras_n) begin
                chk("R8", "precharge cycles >= RPH", (hi_run >= RPH), 1);
                m_row = dram_addr;
                lo_run = 1;
            end else if (!m_prev && dram_ras_n) begin
                chk("R9", "row-open run within window", (lo_run <= RASP), 1);
                hi_run = 1;
            end else if (dram_ras_n) begin
                hi_run++;
            end else begin
                lo_run++;
            end
            m_prev = dram_ras_n;
            if (!dram_cas_n && !dram_ras_n) begin
                m_col = dram_addr[8:0];
                if (!dram_we_n) dmem[int'({m_row, m_col})] = dram_dq_out;
            end
            if (!dram_cas_n && !dram_oe_n) begin
                if (dmem.exists(int'({m_row, m_col}))) dram_dq_in = dmem[int'({m_row, m_col})];
                else dram_dq_in = dflt({m_row, m_col});
            end else begin
                dram_dq_in = 8'h00;
            end
        end
    end

    // Compare the strobes for n cycles, starting at the current falling edge.
    task automatic phase(input string tag, input int n, input logic ras, input logic cas,
                         input logic we, input logic oe, input logic [11:0] adr, input logic chk_adr);
        for (int i = 0; i < n; i++) begin
            chk(tag, "ras_n", dram_ras_n, ras);
            chk(tag, "cas_n", dram_cas_n, cas);
            chk(tag, "we_n", dram_we_n, we);
            chk(tag, "oe_n", dram_oe_n, oe);
            chk(tag, "dq_oe", dram_dq_oe, !we);
            if (chk_adr) chk(tag, "addr", dram_addr, adr);
            @(negedge clk);
        end
    endtask

    task automatic run_access(input string tag, input logic wr, input logic [20:0] a,
                              input logic [7:0] wd, input logic from_page);
        logic [7:0] exp;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        chk(tag, "req_ready", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (!from_page) phase("R2", RCDH, 0, 1, 1, 1, a[20:9], 1);
        if (wr) chk("R5", "dq_out in setup", dram_dq_out, wd);
        phase(wr ? "R5" : "R3", 1, 0, 1, !wr, wr, {3'b000, a[8:0]}, 1);
        phase(wr ? "R5" : "R4", CASH, 0, 0, !wr, wr, {3'b000, a[8:0]}, 1);
        if (!wr) begin
            exp = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
            chk("R4", "rsp_valid", rsp_valid, 1);
            chk(tag, "rsp_rdata", rsp_rdata, exp);
        end else begin
            chk("R5", "rsp_valid on write", rsp_valid, 0);
            shadow[int'(a)] = wd;
        end
        phase("R6", CPH, 0, 1, 1, 1, {3'b000, a[8:0]}, 1);
        chk("R4", "rsp_valid after pulse", rsp_valid, 0);
        chk("R6", "page open ras_n", dram_ras_n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "ras_n", dram_ras_n, 1);
        chk("R1", "cas_n", dram_cas_n, 1);
        chk("R1", "we_n", dram_we_n, 1);
        chk("R1", "oe_n", dram_oe_n, 1);
        chk("R1", "dq_oe", dram_dq_oe, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
        @(negedge clk);

        run_access("R3", 1'b0, {12'h3A5, 9'h017}, 8'h00, 1'b0);
        run_access("R6", 1'b1, {12'h3A5, 9'h1F0}, 8'hC3, 1'b1);
        run_access("R6", 1'b0, {12'h3A5, 9'h1F0}, 8'h00, 1'b1);

        // Row miss in the open page.
        req_valid = 1'b1; req_write = 1'b1; req_addr = {12'hFFF, 9'h1FF}; req_wdata = 8'h5A;
        #1;
        chk("R7", "req_ready on row miss", req_ready, 0);
        @(negedge clk);
        phase("R7", RPH, 1, 1, 1, 1, 12'h000, 0);
        run_access("R2", 1'b1, {12'hFFF, 9'h1FF}, 8'h5A, 1'b0);

        // Idle page must close by itself.
        begin
            int n = 0;
            while (dram_ras_n == 1'b0 && n < 300) begin
                @(negedge clk);
                n++;
            end
            chk("R9", "page closed while idle", dram_ras_n, 1);
            chk("R9", "closed before limit", (n < RASP), 1);
        end
        phase("R8", RPH, 1, 1, 1, 1, 12'h000, 0);

        // Refresh from idle beats a host request.
        ref_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = {12'h001, 9'h000};
        #1;
        chk("R10", "ref_ack", ref_ack, 1);
        chk("R10", "req_ready during grant", req_ready, 0);
        @(negedge clk);
        ref_req = 1'b0;
        phase("R10", 1, 1, 0, 1, 1, 12'h000, 0);
        phase("R10", RASH, 0, 0, 1, 1, 12'h000, 0);
        phase("R10", RPH, 1, 1, 1, 1, 12'h000, 0);
        run_access("R10", 1'b0, {12'h001, 9'h000}, 8'h00, 1'b0);

        // Refresh request inside an open page.
        ref_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = {12'h001, 9'h005};
        #1;
        chk("R11", "req_ready in page with refresh", req_ready, 0);
        chk("R11", "ref_ack in page", ref_ack, 0);
        @(negedge clk);
        chk("R11", "ref_ack in precharge", ref_ack, 0);
        phase("R11", RPH, 1, 1, 1, 1, 12'h000, 0);
        #1;
        chk("R11", "ref_ack back in idle", ref_ack, 1);
        @(negedge clk);
        ref_req = 1'b0; req_valid = 1'b0;
        phase("R11", 1, 1, 0, 1, 1, 12'h000, 0);
        phase("R11", RASH, 0, 0, 1, 1, 12'h000, 0);
        phase("R11", RPH, 1, 1, 1, 1, 12'h000, 0);

        run_access("R5", 1'b0, {12'hFFF, 9'h1FF}, 8'h00, 1'b0);
        run_access("R4", 1'b0, {12'hFFF, 9'h1FF}, 8'h00, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule